// File: doc/BRIEF.md
# Single-Transfer Address and Alignment Unit

This block serves one register-to-memory or memory-to-register transfer at a time. It takes a base register value and an offset, which is either a zero-extended immediate or a second register shifted left by 0 to 31 places. It adds or subtracts the offset and chooses the transfer address for either the pre-indexed or the post-indexed ordering. It also gives the value to write back into the base register, and says whether that write happens.

For stores, the block drives the byte-lane enables and lays out the write data: a full word, or one byte copied onto every lane. For loads, the memory returns a 32-bit word one cycle after the strobe. The block then gives the register result: the whole word, or the addressed byte zero-extended. A word access whose address is not 4-byte aligned raises a fault. That fault holds back the memory strobe and the base writeback.

Top module: `ldst_addr_unit`

## Requirements
- R1: Post-indexed request (`req_pre`=0): `mem_addr` equals `base_val`, `wb_en` is 1 whatever `req_wb` is, and `wb_value` is `base_val` combined with the offset.
- R2: Pre-indexed request (`req_pre`=1): `mem_addr` and `wb_value` both equal `base_val` combined with the offset, and `wb_en` follows `req_wb`.
- R3: With `off_sel`=0 the offset is `imm_off` zero-extended to 32 bits. With `off_sel`=1 it is `off_reg` shifted left logically by `off_shamt` (0 to 31), with bits shifted out lost.
- R4: `req_up`=1 adds the offset to the base and `req_up`=0 subtracts it, modulo 2^32.
- R5: A word request (`req_byte`=0) whose address has bits 1:0 nonzero sets `align_fault`=1 and forces `mem_strobe`=0 and `wb_en`=0. No `ld_valid` follows it.
- R6: A byte request (`req_byte`=1) never faults, at any address.
- R7: Stores: word gives `mem_be`=4'b1111 and `mem_wdata`=`st_data`. Byte gives `mem_be` with only bit `mem_addr[1:0]` set, and `mem_wdata` = `st_data[7:0]` repeated on all four lanes. `mem_write` is 1 for stores (`req_load`=0).
- R8: One cycle after a load strobe, `ld_valid`=1 and `ld_result` is taken from `rd_data`. A word load gives `rd_data` itself. A byte load gives lane k = `rd_data[8k+7:8k]` (k = address bits 1:0, little-endian), zero-extended.
- R9: With `req_valid`=0, `mem_strobe`, `wb_en` and `align_fault` are 0. After reset, `ld_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A transfer is presented this cycle |
| req_load | input | 1 | 1 load, 0 store |
| req_byte | input | 1 | 1 unsigned byte, 0 word |
| req_pre | input | 1 | 1 pre-indexed, 0 post-indexed |
| req_up | input | 1 | 1 add offset, 0 subtract |
| req_wb | input | 1 | Writeback request (pre-indexed only) |
| off_sel | input | 1 | 0 immediate offset, 1 shifted register offset |
| base_val | input | 32 | Base register value |
| imm_off | input | 12 | Immediate offset |
| off_reg | input | 32 | Offset register value |
| off_shamt | input | 5 | Left shift applied to off_reg |
| st_data | input | 32 | Store source register |
| rd_data | input | 32 | Memory read word, one cycle after strobe |
| mem_strobe | output | 1 | Memory access request |
| mem_write | output | 1 | Access is a write |
| mem_addr | output | 32 | Transfer address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Laid-out write data |
| wb_en | output | 1 | Base register writeback enable |
| wb_value | output | 32 | New base register value |
| align_fault | output | 1 | Misaligned word access |
| ld_valid | output | 1 | Load result valid |
| ld_result | output | 32 | Load result for the destination register |

## Verification
The assertions check the following on every cycle:
- An idle cycle and a faulting cycle never strobe memory or write back the base.
- Byte accesses never fault and enable exactly one lane.
- A post-indexed access always uses the raw base and always writes back.
- `ld_valid` comes exactly one cycle after a load strobe, and at no other time.

The scenarios show what only concrete values can: the add and subtract arithmetic, the 31-place shift, the zero-extension of the immediate, the choice of lane for each of the four byte addresses, and the replication of store data.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned LANES   = XLEN / 8;
  localparam int unsigned LSEL_W  = $clog2(LANES);
  localparam int unsigned SHAMT_W = $clog2(XLEN);

  typedef enum logic {SZ_WORD = 1'b0, SZ_BYTE = 1'b1} xfer_size_e;
endpackage

// File: rtl/lsu_offset_gen.sv
module lsu_offset_gen #(
  parameter int unsigned W       = 32,
  parameter int unsigned IMM_W   = 12,
  parameter int unsigned SHAMT_W = 5
) (
  input  logic               off_sel,
  input  logic [IMM_W-1:0]   imm_off,
  input  logic [W-1:0]       off_reg,
  input  logic [SHAMT_W-1:0] off_shamt,
  output logic [W-1:0]       offset
);
  logic [W-1:0] imm_ext;
  logic [W-1:0] reg_shl;

  always_comb begin
    imm_ext = {{(W-IMM_W){1'b0}}, imm_off};
    reg_shl = off_reg << off_shamt;
    offset  = off_sel ? reg_shl : imm_ext;
  end
endmodule

// File: rtl/lsu_addr_calc.sv
module lsu_addr_calc #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] base_val,
  input  logic [W-1:0] offset,
  input  logic         req_pre,
  input  logic         req_up,
  input  logic         req_wb,
  output logic [W-1:0] xfer_addr,
  output logic [W-1:0] new_base,
  output logic         wb_want
);
  logic [W-1:0] moved;

  always_comb begin
    moved     = req_up ? (base_val + offset) : (base_val - offset);
    xfer_addr = req_pre ? moved : base_val;
    new_base  = moved;
    wb_want   = req_pre ? req_wb : 1'b1;
  end
endmodule

// File: rtl/lsu_lane_ctrl.sv
module lsu_lane_ctrl #(
  parameter int unsigned W = 32
) (
  input  logic                       is_byte,
  input  logic [$clog2(W/8)-1:0]     lane,
  input  logic [W-1:0]               st_data,
  output logic [W/8-1:0]             be,
  output logic [W-1:0]               wdata,
  output logic                       misaligned
);
  localparam int unsigned NL = W / 8;

  logic [W-1:0] rep;

  for (genvar k = 0; k < NL; k++) begin : g_rep
    assign rep[8*k +: 8] = st_data[7:0];
  end

  always_comb begin
    if (is_byte) begin
      be    = {{(NL-1){1'b0}}, 1'b1} << lane;
      wdata = rep;
    end else begin
      be    = {NL{1'b1}};
      wdata = st_data;
    end
    misaligned = !is_byte && (lane != '0);
  end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align #(
  parameter int unsigned W = 32
) (
  input  logic                   is_byte,
  input  logic [$clog2(W/8)-1:0] lane,
  input  logic [W-1:0]           rd_data,
  output logic [W-1:0]           result
);
  localparam int unsigned NL = W / 8;

  logic [7:0] lane_bytes [NL];

  for (genvar k = 0; k < NL; k++) begin : g_lane
    assign lane_bytes[k] = rd_data[8*k +: 8];
  end

  always_comb begin
    if (is_byte) result = {{(W-8){1'b0}}, lane_bytes[lane]};
    else         result = rd_data;
  end
endmodule

// File: rtl/ldst_addr_unit.sv
module ldst_addr_unit
  import lsu_pkg::*;
#(
  parameter int unsigned IMM_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_load,
  input  logic               req_byte,
  input  logic               req_pre,
  input  logic               req_up,
  input  logic               req_wb,
  input  logic               off_sel,
  input  logic [XLEN-1:0]    base_val,
  input  logic [IMM_W-1:0]   imm_off,
  input  logic [XLEN-1:0]    off_reg,
  input  logic [SHAMT_W-1:0] off_shamt,
  input  logic [XLEN-1:0]    st_data,
  input  logic [XLEN-1:0]    rd_data,
  output logic               mem_strobe,
  output logic               mem_write,
  output logic [XLEN-1:0]    mem_addr,
  output logic [LANES-1:0]   mem_be,
  output logic [XLEN-1:0]    mem_wdata,
  output logic               wb_en,
  output logic [XLEN-1:0]    wb_value,
  output logic               align_fault,
  output logic               ld_valid,
  output logic [XLEN-1:0]    ld_result
);
  logic [XLEN-1:0]   offset;
  logic [XLEN-1:0]   xfer_addr;
  logic              wb_want;
  logic              misaligned;
  xfer_size_e        size_now;

  logic              pend_q, pend_d;
  logic [LSEL_W-1:0] lane_q, lane_d;
  xfer_size_e        size_q, size_d;
  logic              cap_en;

  assign size_now = req_byte ? SZ_BYTE : SZ_WORD;

  lsu_offset_gen #(.W(XLEN), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)) u_off (
    .off_sel(off_sel), .imm_off(imm_off), .off_reg(off_reg),
    .off_shamt(off_shamt), .offset(offset)
  );

  lsu_addr_calc #(.W(XLEN)) u_addr (
    .base_val(base_val), .offset(offset), .req_pre(req_pre),
    .req_up(req_up), .req_wb(req_wb), .xfer_addr(xfer_addr),
    .new_base(wb_value), .wb_want(wb_want)
  );

  lsu_lane_ctrl #(.W(XLEN)) u_lane (
    .is_byte(size_now == SZ_BYTE), .lane(xfer_addr[LSEL_W-1:0]),
    .st_data(st_data), .be(mem_be), .wdata(mem_wdata),
    .misaligned(misaligned)
  );

  always_comb begin
    mem_addr    = xfer_addr;
    align_fault = req_valid && misaligned;
    mem_strobe  = req_valid && !misaligned;
    mem_write   = !req_load;
    wb_en       = mem_strobe && wb_want;
  end

  // capture the lane of an accepted load for the return cycle
  always_comb begin
    cap_en = mem_strobe && req_load;
    pend_d = cap_en;
    lane_d = cap_en ? xfer_addr[LSEL_W-1:0] : lane_q;
    size_d = cap_en ? size_now : size_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lane_q <= '0;
      size_q <= SZ_WORD;
    end else begin
      pend_q <= pend_d;
      lane_q <= lane_d;
      size_q <= size_d;
    end
  end

  lsu_load_align #(.W(XLEN)) u_ld (
    .is_byte(size_q == SZ_BYTE), .lane(lane_q),
    .rd_data(rd_data), .result(ld_result)
  );

  assign ld_valid = pend_q;
endmodule

// File: rtl/ldst_addr_unit_chk.sv
module ldst_addr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_load,
  input logic        req_byte,
  input logic        req_pre,
  input logic [31:0] base_val,
  input logic        mem_strobe,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic        wb_en,
  input logic        align_fault,
  input logic        ld_valid
);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!mem_strobe && !wb_en && !align_fault));

  // R5
  fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> (!mem_strobe && !wb_en));

  // R6
  byte_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_byte) |-> !align_fault);

  // R7
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && req_byte) |-> ($countones(mem_be) == 1));

  // R1
  post_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_pre && !align_fault) |-> (wb_en && mem_addr == base_val));

  // R8
  ld_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && req_load) |=> ld_valid);

  // R8
  ld_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_strobe || !req_load) |=> !ld_valid);
endmodule

bind ldst_addr_unit ldst_addr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_load(req_load),
  .req_byte(req_byte), .req_pre(req_pre), .base_val(base_val),
  .mem_strobe(mem_strobe), .mem_addr(mem_addr), .mem_be(mem_be),
  .wb_en(wb_en), .align_fault(align_fault), .ld_valid(ld_valid)
);

// File: tb/ldst_addr_unit_test.sv
module ldst_addr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_load = 0, req_byte = 0, req_pre = 0;
  logic        req_up = 0, req_wb = 0, off_sel = 0;
  logic [31:0] base_val = 0, off_reg = 0, st_data = 0, rd_data = 0;
  logic [11:0] imm_off = 0;
  logic [4:0]  off_shamt = 0;
  logic        mem_strobe, mem_write, wb_en, align_fault, ld_valid;
  logic [31:0] mem_addr, mem_wdata, wb_value, ld_result;
  logic [3:0]  mem_be;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  ldst_addr_unit uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic ld, logic by, logic pre, logic up, logic wb,
                       logic sel, logic [31:0] base, logic [11:0] imm,
                       logic [31:0] oreg, logic [4:0] sh, logic [31:0] sd);
    @(negedge clk);
    req_valid = 1; req_load = ld; req_byte = by; req_pre = pre; req_up = up;
    req_wb = wb; off_sel = sel; base_val = base; imm_off = imm; off_reg = oreg;
    off_shamt = sh; st_data = sd;
    #5;
  endtask

  task automatic idle_and_return(logic [31:0] rd);
    @(posedge clk); #5;
    req_valid = 0; rd_data = rd;
    #4;
  endtask

  task automatic t_reset;
    chk("R9 ld_valid after reset", {31'b0, ld_valid}, 32'd0);
    chk("R9 idle strobe", {31'b0, mem_strobe}, 32'd0);
    chk("R9 idle wb_en", {31'b0, wb_en}, 32'd0);
  endtask

  task automatic t_post_word_load;
    drive(1, 0, 0, 1, 0, 0, 32'h1000, 12'd4, 0, 0, 0);
    chk("R1 post addr", mem_addr, 32'h1000);
    chk("R1 post wb_en", {31'b0, wb_en}, 32'd1);
    chk("R1 post wb_value", wb_value, 32'h1004);
    idle_and_return(32'hCAFEF00D);
    chk("R8 word ld_valid", {31'b0, ld_valid}, 32'd1);
    chk("R8 word result", ld_result, 32'hCAFEF00D);
  endtask

  task automatic t_pre_sub_nowb;
    drive(1, 0, 1, 0, 0, 0, 32'h2000, 12'd8, 0, 0, 0);
    chk("R4 R2 pre sub addr", mem_addr, 32'h1FF8);
    chk("R2 pre no wb", {31'b0, wb_en}, 32'd0);
    chk("R2 pre wb_value", wb_value, 32'h1FF8);
    idle_and_return(0);
  endtask

  task automatic t_pre_reg_wb;
    drive(0, 0, 1, 1, 1, 1, 32'h100, 0, 32'd3, 5'd2, 32'h11223344);
    chk("R3 reg shift addr", mem_addr, 32'h10C);
    chk("R2 pre wb_en", {31'b0, wb_en}, 32'd1);
    chk("R2 pre wb value", wb_value, 32'h10C);
    chk("R7 word be", {28'b0, mem_be}, 32'hF);
    chk("R7 word wdata", mem_wdata, 32'h11223344);
    chk("R7 write flag", {31'b0, mem_write}, 32'd1);
    idle_and_return(0);
    chk("R8 no ld_valid after store", {31'b0, ld_valid}, 32'd0);
  endtask

  task automatic t_shift31_and_imm;
    drive(1, 0, 1, 1, 0, 1, 32'h0, 0, 32'h3, 5'd31, 0);
    chk("R3 shift 31", mem_addr, 32'h80000000);
    drive(1, 0, 1, 1, 0, 0, 32'h1000, 12'hFFC, 32'hFFFF_FFFF, 5'd7, 0);
    chk("R3 imm zero-extend", mem_addr, 32'h1FFC);
    drive(1, 0, 1, 0, 0, 0, 32'h0, 12'd4, 0, 0, 0);
    chk("R4 wrap subtract", mem_addr, 32'hFFFFFFFC);
    idle_and_return(0);
  endtask

  task automatic t_byte_loads;
    for (int k = 0; k < 4; k++) begin
      drive(1, 1, 0, 1, 0, 0, 32'h400 + k, 12'd1, 0, 0, 0);
      chk("R6 byte no fault", {31'b0, align_fault}, 32'd0);
      chk("R6 byte strobe", {31'b0, mem_strobe}, 32'd1);
      idle_and_return(32'hA1B2C3D4);
      chk("R8 byte lane", ld_result, {24'b0, 8'(32'hA1B2C3D4 >> (8*k))});
    end
  endtask

  task automatic t_byte_store;
    drive(0, 1, 1, 1, 0, 0, 32'h800, 12'd3, 0, 0, 32'h1234565A);
    chk("R7 byte be", {28'b0, mem_be}, 32'h8);
    chk("R7 byte wdata", mem_wdata, 32'h5A5A5A5A);
    idle_and_return(0);
  endtask

  task automatic t_misaligned;
    drive(1, 0, 0, 1, 1, 0, 32'h1002, 12'd4, 0, 0, 0);
    chk("R5 fault", {31'b0, align_fault}, 32'd1);
    chk("R5 no strobe", {31'b0, mem_strobe}, 32'd0);
    chk("R5 no wb", {31'b0, wb_en}, 32'd0);
    idle_and_return(32'hFFFFFFFF);
    chk("R5 no ld_valid", {31'b0, ld_valid}, 32'd0);
    chk("R9 idle fault low", {31'b0, align_fault}, 32'd0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    #2;
    t_reset();
    t_post_word_load();
    t_pre_sub_nowb();
    t_pre_reg_wb();
    t_shift31_and_imm();
    t_byte_loads();
    t_byte_store();
    t_misaligned();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule